// File: doc/BRIEF.md
# Banked Level-Triggered Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised number of banks, each holding 32 sources. Every bank exposes five word registers inside a 32-byte window: the synchronised raw levels, the current mask, a write-one-to-set strobe that masks sources, a write-one-to-clear strobe that unmasks them, and a pending view equal to the levels with the masked sources removed. The banks follow one another at a 0x20-byte stride, so bank `n` starts at `n * 0x20`.

Software never writes the mask directly. It sets or clears single bits atomically through the two strobe registers, so no read-modify-write sequence is needed. A request stays visible for as long as its input line is held high, and there is no acknowledge register. One registered output, raised whenever any unmasked source in any bank is active, goes to a parent interrupt controller.

The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit of every bank is 1, every pending bit is 0 and `irq_out` is low.
- R2: The status register (offset 0x00) returns the source levels after a two-flop synchroniser, so a change at the inputs shows up two clock edges later. Writes to it have no effect.
- R3: Writing the set-mask register (offset 0x08) forces to 1 the mask bits where the write data holds a 1. Bits written as 0 keep their value.
- R4: Writing the clear-mask register (offset 0x0C) forces to 0 the mask bits where the write data holds a 1. Bits written as 0 keep their value.
- R5: The mask register (offset 0x04) reads the current mask. A direct write to it has no effect, and the mask changes only through the set and clear strobes.
- R6: The pending register (offset 0x10) reads status AND NOT mask. Writes to it have no effect.
- R7: `irq_out` is a register that goes high one clock edge after any pending bit of any bank is 1, and low one edge after all pending bits are 0.
- R8: Reads of set-mask, of clear-mask, of offsets 0x14 to 0x1C, and of any bank index at or beyond `NUM_BANKS` return zero. Writes to a bank that does not exist have no effect.
- R9: Bank `n` answers at byte address `n*0x20 + offset` (address bits [4:0] select the offset, the bits above them select the bank). A strobe write to one bank leaves the mask of every other bank unchanged.
- R10: Writing 0xFFFFFFFF to a bank's set-mask register masks all 32 of its sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*32 | Level request lines; bit `32*n+i` is source `i` of bank `n` |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Registered combined request to the parent controller |

## Verification
A strobe write to the mask and a change of a source level can occur in the same cycle, and both feed the pending term behind `irq_out`. The bench drives the unmask write and the rising source level at the same negative edge, and also the reverse case: a mask write while the source falls. It then samples `irq_out` edge by edge. The write acts after one edge and the level after two, so the output must stay low through the second edge and rise after the third. Random runs mix strobe writes, stray writes and level changes, and compare every register of both banks with a bench model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int BANK_W      = 32;
  localparam int OFFS_BITS   = 5;   // 0x20 stride per bank

  localparam logic [4:0] OFFS_LEVEL = 5'h00;
  localparam logic [4:0] OFFS_MASK  = 5'h04;
  localparam logic [4:0] OFFS_SET   = 5'h08;
  localparam logic [4:0] OFFS_CLR   = 5'h0C;
  localparam logic [4:0] OFFS_PEND  = 5'h10;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_MASK,
    SEL_SET,
    SEL_CLR,
    SEL_PEND,
    SEL_NONE
  } reg_sel_e;

  // Map the in-bank byte offset to a register selector.
  function automatic reg_sel_e decode_offset(input logic [4:0] offs);
    case (offs)
      OFFS_LEVEL: return SEL_LEVEL;
      OFFS_MASK:  return SEL_MASK;
      OFFS_SET:   return SEL_SET;
      OFFS_CLR:   return SEL_CLR;
      OFFS_PEND:  return SEL_PEND;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Next mask value from the set and clear strobe bits.
  function automatic logic [BANK_W-1:0] mask_next(
    input logic [BANK_W-1:0] cur,
    input logic [BANK_W-1:0] set_bits,
    input logic [BANK_W-1:0] clr_bits
  );
    return (cur | set_bits) & ~clr_bits;
  endfunction

  // Pending view: active and not masked.
  function automatic logic [BANK_W-1:0] pend_calc(
    input logic [BANK_W-1:0] level,
    input logic [BANK_W-1:0] mask
  );
    return level & ~mask;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] level,
  input  logic [BANK_W-1:0] set_bits,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [BANK_W-1:0] mask,
  output logic [BANK_W-1:0] pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else        mask <= mask_next(mask, set_bits, clr_bits);
  end

  assign pend = pend_calc(level, mask);

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        we,
  input  logic [BANK_W-1:0]           wdata,
  input  logic [NUM_BANKS*BANK_W-1:0] level_all,
  input  logic [NUM_BANKS*BANK_W-1:0] mask_all,
  input  logic [NUM_BANKS*BANK_W-1:0] pend_all,
  output logic [NUM_BANKS*BANK_W-1:0] set_bits_all,
  output logic [NUM_BANKS*BANK_W-1:0] clr_bits_all,
  output logic [BANK_W-1:0]           rdata,
  output logic                        rd_hit
);

  localparam int BIDX_W = ADDR_W - OFFS_BITS;

  logic [BIDX_W-1:0] bidx;
  reg_sel_e          sel;
  logic              bank_ok;

  assign bidx    = addr[ADDR_W-1:OFFS_BITS];
  assign sel     = decode_offset(addr[OFFS_BITS-1:0]);
  assign bank_ok = (32'(bidx) < NUM_BANKS);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
      logic hit_b;
      assign hit_b = we && bank_ok && (bidx == BIDX_W'(b));
      assign set_bits_all[b*BANK_W +: BANK_W] = (hit_b && sel == SEL_SET) ? wdata : '0;
      assign clr_bits_all[b*BANK_W +: BANK_W] = (hit_b && sel == SEL_CLR) ? wdata : '0;
    end
  endgenerate

  assign rd_hit = bank_ok && (sel == SEL_LEVEL || sel == SEL_MASK || sel == SEL_PEND);

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_ok && bidx == BIDX_W'(b)) begin
        case (sel)
          SEL_LEVEL: rdata = level_all[b*BANK_W +: BANK_W];
          SEL_MASK:  rdata = mask_all[b*BANK_W +: BANK_W];
          SEL_PEND:  rdata = pend_all[b*BANK_W +: BANK_W];
          default:   rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_src,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        irq_out
);

  localparam int SRC_W = NUM_BANKS * BANK_W;

  // Named internal events, observed by the bound checker.
  logic [SRC_W-1:0] level_all;
  logic [SRC_W-1:0] mask_all;
  logic [SRC_W-1:0] pend_all;
  logic [SRC_W-1:0] set_bits_all;
  logic [SRC_W-1:0] clr_bits_all;
  logic             pend_any;
  logic             rd_hit;

  irq_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (irq_src),
    .d_out (level_all)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_bank bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_all[b*BANK_W +: BANK_W]),
        .set_bits (set_bits_all[b*BANK_W +: BANK_W]),
        .clr_bits (clr_bits_all[b*BANK_W +: BANK_W]),
        .mask     (mask_all[b*BANK_W +: BANK_W]),
        .pend     (pend_all[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  irq_bus_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
    .addr         (bus_addr),
    .we           (bus_we),
    .wdata        (bus_wdata),
    .level_all    (level_all),
    .mask_all     (mask_all),
    .pend_all     (pend_all),
    .set_bits_all (set_bits_all),
    .clr_bits_all (clr_bits_all),
    .rdata        (bus_rdata),
    .rd_hit       (rd_hit)
  );

  assign pend_any = |pend_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_any;
  end

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] mask_all,
  input logic [W-1:0] set_bits_all,
  input logic [W-1:0] clr_bits_all,
  input logic         pend_any,
  input logic         irq_out,
  input logic         rd_hit,
  input logic [31:0]  bus_rdata
);

  // R7: the combined line follows the pending reduction one edge later
  a_r7_out_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(pend_any)));

  // R3: every set strobe bit leaves its mask bit at 1
  a_r3_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits_all) |=> ((mask_all & $past(set_bits_all)) == $past(set_bits_all)));

  // R4: every clear strobe bit leaves its mask bit at 0
  a_r4_clr_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits_all) |=> ((mask_all & $past(clr_bits_all)) == '0));

  // R5: without a strobe the mask holds its value
  a_r5_mask_only_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits_all == '0 && clr_bits_all == '0) |=> $stable(mask_all));

  // R8: addresses without a readable register return zero
  a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata == '0));

endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(.W(NUM_BANKS*32)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mask_all     (mask_all),
  .set_bits_all (set_bits_all),
  .clr_bits_all (clr_bits_all),
  .pend_any     (pend_any),
  .irq_out      (irq_out),
  .rd_hit       (rd_hit),
  .bus_rdata    (bus_rdata)
);

// File: tb/banked_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb_top;

  localparam int NB = 2;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NB*32-1:0] irq_src = '0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_we = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_mask [NB];

  always #10 clk = ~clk;   // 50 MHz

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] reg_addr(input int bank, input logic [4:0] offs);
    return 8'(bank * 32) | {3'b000, offs};
  endfunction

  function automatic logic [31:0] exp_pend(input int bank);
    return irq_src[bank*32 +: 32] & ~m_mask[bank];
  endfunction

  function automatic logic exp_out();
    logic any = 1'b0;
    for (int b = 0; b < NB; b++) any |= |exp_pend(b);
    return any;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      bus_read(reg_addr(b, 5'h00), d); check({tag, " R2 status"}, d, irq_src[b*32 +: 32]);
      bus_read(reg_addr(b, 5'h04), d); check({tag, " R5 mask"}, d, m_mask[b]);
      bus_read(reg_addr(b, 5'h10), d); check({tag, " R6 pending"}, d, exp_pend(b));
    end
    check({tag, " R7 irq_out"}, {31'b0, irq_out}, {31'b0, exp_out()});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5678));
    for (int b = 0; b < NB; b++) m_mask[b] = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_out in reset", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(reg_addr(0, 5'h04), d); check("R1 mask bank0", d, 32'hFFFF_FFFF);
    bus_read(reg_addr(1, 5'h04), d); check("R1 mask bank1", d, 32'hFFFF_FFFF);
    bus_read(reg_addr(0, 5'h10), d); check("R1 pending bank0", d, 32'h0);

    // R2: latency of status, two edges
    @(negedge clk);
    irq_src[5] = 1'b1;
    @(negedge clk);
    bus_read(reg_addr(0, 5'h00), d); check("R2 status after 1 edge", d, 32'h0);
    @(negedge clk);
    bus_read(reg_addr(0, 5'h00), d); check("R2 status after 2 edges", d, 32'h20);
    // R2: write to status ignored
    bus_write(reg_addr(0, 5'h00), 32'h0);
    bus_read(reg_addr(0, 5'h00), d); check("R2 status write ignored", d, 32'h20);
    check("R1 irq_out masked", {31'b0, irq_out}, 32'h0);

    // R4 + R7: unmask bit 5, irq_out one edge after mask changes
    @(negedge clk);
    bus_addr = reg_addr(0, 5'h0C); bus_we = 1'b1; bus_wdata = 32'h20;
    @(negedge clk);
    bus_we = 1'b0;
    m_mask[0] = 32'hFFFF_FFDF;
    bus_read(reg_addr(0, 5'h04), d); check("R4 clear strobe", d, 32'hFFFF_FFDF);
    check("R7 irq_out not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 irq_out one edge later", {31'b0, irq_out}, 32'h1);

    // R3: set with zeros elsewhere
    bus_write(reg_addr(0, 5'h08), 32'h20);
    m_mask[0] = '1;
    @(negedge clk);
    check_all("R3 set strobe");

    // R5: direct mask write ignored
    bus_write(reg_addr(0, 5'h04), 32'h0);
    bus_read(reg_addr(0, 5'h04), d); check("R5 direct write ignored", d, 32'hFFFF_FFFF);
    // R6: write to pending ignored
    bus_write(reg_addr(0, 5'h10), 32'hFFFF_FFFF);
    bus_read(reg_addr(0, 5'h10), d); check("R6 pending write ignored", d, 32'h0);

    // R9: bank stride and isolation
    bus_write(reg_addr(1, 5'h0C), 32'hF0F0_0000);
    m_mask[1] = 32'h0F0F_FFFF;
    bus_read(reg_addr(1, 5'h04), d); check("R9 bank1 mask", d, 32'h0F0F_FFFF);
    bus_read(reg_addr(0, 5'h04), d); check("R9 bank0 untouched", d, 32'hFFFF_FFFF);

    // R8: zero reads and ignored writes to a missing bank
    bus_read(reg_addr(0, 5'h08), d); check("R8 set reads zero", d, 32'h0);
    bus_read(reg_addr(1, 5'h0C), d); check("R8 clear reads zero", d, 32'h0);
    bus_read(reg_addr(0, 5'h14), d); check("R8 unused offset", d, 32'h0);
    bus_read(reg_addr(2, 5'h04), d); check("R8 bank 2 reads zero", d, 32'h0);
    bus_write(reg_addr(2, 5'h0C), 32'hFFFF_FFFF);
    bus_write(reg_addr(7, 5'h0C), 32'hFFFF_FFFF);
    bus_read(reg_addr(0, 5'h04), d); check("R8 missing bank write bank0", d, m_mask[0]);
    bus_read(reg_addr(1, 5'h04), d); check("R8 missing bank write bank1", d, m_mask[1]);

    // R10: all ones masks the whole bank
    bus_write(reg_addr(1, 5'h08), 32'hFFFF_FFFF);
    m_mask[1] = '1;
    bus_read(reg_addr(1, 5'h04), d); check("R10 all masked", d, 32'hFFFF_FFFF);

    // Same-cycle case: unmask write and rising level at one negedge
    irq_src = '0;
    settle();
    @(negedge clk);
    irq_src[32+3] = 1'b1;
    bus_addr = reg_addr(1, 5'h0C); bus_we = 1'b1; bus_wdata = 32'h8;
    @(negedge clk);   // edge k: mask changed
    bus_we = 1'b0;
    m_mask[1] = 32'hFFFF_FFF7;
    check("R7 same-cycle after k", {31'b0, irq_out}, 32'h0);
    @(negedge clk);   // edge k+1: level visible
    check("R7 same-cycle after k+1", {31'b0, irq_out}, 32'h0);
    @(negedge clk);   // edge k+2
    check("R7 same-cycle after k+2", {31'b0, irq_out}, 32'h1);
    // Reverse: mask set while the level falls
    @(negedge clk);
    irq_src[32+3] = 1'b0;
    bus_addr = reg_addr(1, 5'h08); bus_we = 1'b1; bus_wdata = 32'h8;
    @(negedge clk);
    bus_we = 1'b0;
    m_mask[1] = '1;
    check("R7 masked then dropped", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R7 low after mask", {31'b0, irq_out}, 32'h0);

    // Random mix of strobes, stray writes and level changes
    for (int it = 0; it < 300; it++) begin
      int op;
      int bk;
      logic [31:0] v;
      op = int'($urandom_range(0, 4));
      bk = int'($urandom_range(0, NB - 1));
      v  = $urandom();
      if ($urandom_range(0, 3) == 0) v = v & $urandom() & $urandom();
      case (op)
        0: begin bus_write(reg_addr(bk, 5'h08), v); m_mask[bk] = m_mask[bk] | v; end
        1: begin bus_write(reg_addr(bk, 5'h0C), v); m_mask[bk] = m_mask[bk] & ~v; end
        2: bus_write(reg_addr(bk, 5'(4 * $urandom_range(0, 7)) & 5'h14), v);
        default: begin
          @(negedge clk);
          irq_src[bk*32 +: 32] = v & $urandom();
        end
      endcase
      if (op == 2) begin
        // stray writes may only hit status, mask, pending or unused offsets
      end
      settle();
      check_all("rand R3 R4");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule